// File: doc/BRIEF.md
# Temperature Alert Controller

This block watches a stream of signed temperature readings from a sensor front end and raises one interrupt when any of three programmable alarm levels is passed. Software programs it over a small memory-mapped bus with byte addresses and 32-bit data. It sets a run bit and a monitoring mode, then chooses how often the front end is asked for a new reading. Each of the three channels gets its own threshold and its own enable. Pending alarms are serviced through one packed interrupt-control word.

Readings arrive as 9-bit two's-complement whole degrees with a one-cycle valid strobe. A pacing timer drives a one-cycle sample-request strobe toward the front end, either once per activation or continuously. Each channel holds a sticky status bit. The interrupt line is the registered OR of every channel whose status and interrupt enable are both set.

Top module: `thermal_alert_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0, `alert_irq` is 0 and `sample_req` is 0.
- R2: Reads return data on `bus_rdata` one cycle after `bus_rd`. Register word map: run 0x00 (bit 0), mode 0x04 (bits 3:0), repeat 0x08 (bit 24 = endless, bits 3:0 = period code), channel thresholds at 0x10, 0x14 and 0x18 (bits 23:16 = threshold, bit 0 = channel enable), interrupt control 0x20. Undefined bits, unmapped addresses and addresses with nonzero bits 1:0 read 0, and writes to them have no effect.
- R3: Channel status is set when the channel enable is 1, a valid sample has sign bit 8 clear, and its low 8 bits are strictly greater than the unsigned threshold. Negative samples never set status.
- R4: In the interrupt-control word, channel n has its interrupt enable at bit 4n (read/write), its status at bit 4n+1 (read-only) and its clear at bit 4n+2 (write 1, reads 0). Status stays set until a 1 is written to the clear bit. Writing 0 there has no effect.
- R5: If a set condition and a clear write for the same channel fall in the same cycle, the status ends up set.
- R6: `alert_irq` equals the OR over channels of (status AND interrupt enable), delayed by one register stage.
- R7: Monitoring is active only while the run bit is 1 and the mode field equals 0x5. While inactive, no sample request is issued and no status bit is set.
- R8: With endless repeat, `sample_req` pulses every PRESCALE·2^code cycles. The first pulse comes that many cycles after the activating write. Codes above 9 act as 9.
- R9: Without endless repeat, exactly one request is issued per activation. Deactivating and reactivating arms one more.
- R10: A sample sets only the status of the channels whose own condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| temp_valid | input | 1 | Sample valid strobe |
| temp_value | input | 9 | Signed temperature sample |
| sample_req | output | 1 | One-cycle request for a new sample |
| alert_irq | output | 1 | Level interrupt |

## Verification
A corrupted status bit reaches the ports two ways. It shows on `alert_irq` one cycle later when its interrupt enable is set. It also shows in the interrupt-control readback on the next read. A wrong pacing counter shows as a misplaced or missing `sample_req` pulse, either at the first interval after activation or at the one after it. Sweeping every 9-bit sample against several threshold sets exposes comparator errors at the exact boundary value and around the sign bit.

// File: rtl/thermal_alert_pkg.sv
`timescale 1ns/1ps
package thermal_alert_pkg;
  localparam int NUM_CH     = 3;
  localparam int TEMP_W     = 9;
  localparam int THR_W      = 8;
  localparam int DATA_W     = 32;
  localparam int CODE_W     = 4;
  localparam int MODE_W     = 4;
  localparam int MAX_CODE   = 9;
  localparam logic [MODE_W-1:0] MODE_TEMP = 4'h5;
  // word indexes (byte address / 4)
  localparam int WI_RUN     = 0;
  localparam int WI_MODE    = 1;
  localparam int WI_REPEAT  = 2;
  localparam int WI_THR0    = 4;
  localparam int WI_INTCTL  = 8;
  // field positions
  localparam int THR_LSB     = 16;
  localparam int ENDLESS_BIT = 24;
  localparam int CH_STRIDE   = 4;
  localparam int IE_OFS      = 0;
  localparam int ST_OFS      = 1;
  localparam int CLR_OFS     = 2;
endpackage

// File: rtl/ta_regbank.sv
`timescale 1ns/1ps
module ta_regbank
  import thermal_alert_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NUM_CH-1:0]            status,
  output logic [DATA_W-1:0]            rdata,
  output logic                         run_q,
  output logic [MODE_W-1:0]            mode_q,
  output logic                         endless_q,
  output logic [CODE_W-1:0]            code_q,
  output logic [NUM_CH-1:0][THR_W-1:0] thr_q,
  output logic [NUM_CH-1:0]            thr_en_q,
  output logic [NUM_CH-1:0]            ie_q,
  output logic [NUM_CH-1:0]            clr_pulse
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              aligned;
  logic              sel_run, sel_mode, sel_rep, sel_int;
  logic [NUM_CH-1:0] sel_thr;
  logic [DATA_W-1:0] rd_word;
  logic              unused_wbits;

  assign widx     = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign sel_run  = aligned && (widx == WIDX_W'(WI_RUN));
  assign sel_mode = aligned && (widx == WIDX_W'(WI_MODE));
  assign sel_rep  = aligned && (widx == WIDX_W'(WI_REPEAT));
  assign sel_int  = aligned && (widx == WIDX_W'(WI_INTCTL));
  assign unused_wbits = ^wdata;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign sel_thr[c]   = aligned && (widx == WIDX_W'(WI_THR0 + c));
    assign clr_pulse[c] = wr_en && sel_int && wdata[CH_STRIDE*c + CLR_OFS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      mode_q    <= '0;
      endless_q <= 1'b0;
      code_q    <= '0;
      thr_q     <= '0;
      thr_en_q  <= '0;
      ie_q      <= '0;
    end else if (wr_en) begin
      if (sel_run)  run_q  <= wdata[0];
      if (sel_mode) mode_q <= wdata[MODE_W-1:0];
      if (sel_rep) begin
        endless_q <= wdata[ENDLESS_BIT];
        code_q    <= wdata[CODE_W-1:0];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (sel_thr[c]) begin
          thr_q[c]    <= wdata[THR_LSB +: THR_W];
          thr_en_q[c] <= wdata[0];
        end
        if (sel_int) ie_q[c] <= wdata[CH_STRIDE*c + IE_OFS];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (sel_run)  rd_word[0] = run_q;
    if (sel_mode) rd_word[MODE_W-1:0] = mode_q;
    if (sel_rep) begin
      rd_word[ENDLESS_BIT]  = endless_q;
      rd_word[CODE_W-1:0]   = code_q;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel_thr[c]) begin
        rd_word[THR_LSB +: THR_W] = thr_q[c];
        rd_word[0]                = thr_en_q[c];
      end
      if (sel_int) begin
        rd_word[CH_STRIDE*c + IE_OFS] = ie_q[c];
        rd_word[CH_STRIDE*c + ST_OFS] = status[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end
endmodule

// File: rtl/ta_pacer.sv
`timescale 1ns/1ps
module ta_pacer
  import thermal_alert_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              endless,
  input  logic [CODE_W-1:0] code,
  output logic              req
);
  localparam int MAX_IVL = PRESCALE << MAX_CODE;
  localparam int CNT_W   = $clog2(MAX_IVL + 1);

  logic [CODE_W-1:0] eff_code;
  logic [CNT_W-1:0]  ivl_m1;
  logic [CNT_W-1:0]  cnt;
  logic              done;

  assign eff_code = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
  assign ivl_m1   = (CNT_W'(PRESCALE) << eff_code) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt  <= '0;
      done <= 1'b0;
      req  <= 1'b0;
    end else if (done) begin
      req <= 1'b0;
    end else if (cnt >= ivl_m1) begin
      req  <= 1'b1;
      cnt  <= '0;
      done <= !endless;
    end else begin
      req <= 1'b0;
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ta_alert_chan.sv
`timescale 1ns/1ps
module ta_alert_chan
  import thermal_alert_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              smp_valid,
  input  logic [TEMP_W-1:0] smp,
  input  logic [THR_W-1:0]  thr,
  input  logic              thr_en,
  input  logic              clr,
  output logic              status
);
  logic hit;

  // non-negative sample strictly above the unsigned threshold
  assign hit = active && thr_en && smp_valid && !smp[TEMP_W-1] &&
               (smp[TEMP_W-2:0] > thr);

  always_ff @(posedge clk) begin
    if (rst)      status <= 1'b0;
    else if (hit) status <= 1'b1;
    else if (clr) status <= 1'b0;
  end
endmodule

// File: rtl/thermal_alert_ctrl.sv
`timescale 1ns/1ps
module thermal_alert_ctrl
  import thermal_alert_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              temp_valid,
  input  logic [TEMP_W-1:0] temp_value,
  output logic              sample_req,
  output logic              alert_irq
);
  logic                         run_q;
  logic [MODE_W-1:0]            mode_q;
  logic                         endless_q;
  logic [CODE_W-1:0]            code_q;
  logic [NUM_CH-1:0][THR_W-1:0] thr_q;
  logic [NUM_CH-1:0]            thr_en_q;
  logic [NUM_CH-1:0]            irq_en;
  logic [NUM_CH-1:0]            clr_pulse;
  logic [NUM_CH-1:0]            alert_status;
  logic                         mon_active;

  assign mon_active = run_q && (mode_q == MODE_TEMP);

  ta_regbank #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr),
    .rd_en     (bus_rd),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .status    (alert_status),
    .rdata     (bus_rdata),
    .run_q     (run_q),
    .mode_q    (mode_q),
    .endless_q (endless_q),
    .code_q    (code_q),
    .thr_q     (thr_q),
    .thr_en_q  (thr_en_q),
    .ie_q      (irq_en),
    .clr_pulse (clr_pulse)
  );

  ta_pacer #(.PRESCALE(PRESCALE)) u_pacer (
    .clk     (clk),
    .rst     (rst),
    .active  (mon_active),
    .endless (endless_q),
    .code    (code_q),
    .req     (sample_req)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    ta_alert_chan u_chan (
      .clk       (clk),
      .rst       (rst),
      .active    (mon_active),
      .smp_valid (temp_valid),
      .smp       (temp_value),
      .thr       (thr_q[c]),
      .thr_en    (thr_en_q[c]),
      .clr       (clr_pulse[c]),
      .status    (alert_status[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) alert_irq <= 1'b0;
    else     alert_irq <= |(alert_status & irq_en);
  end
endmodule

// File: rtl/thermal_alert_chk.sv
`timescale 1ns/1ps
module thermal_alert_chk
  import thermal_alert_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              sample_req,
  input logic              active,
  input logic [NUM_CH-1:0] status,
  input logic [NUM_CH-1:0] ie,
  input logic [NUM_CH-1:0] clr
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq && !sample_req));

  // R7
  idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> !sample_req);

  // R7
  idle_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> ((status & ~$past(status)) == '0));

  // R4
  sticky_status_chk: assert property (@(posedge clk) disable iff (rst)
    ((~status & $past(status) & ~$past(clr)) == '0));

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(status & ie)));
endmodule

bind thermal_alert_ctrl thermal_alert_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq        (alert_irq),
  .sample_req (sample_req),
  .active     (mon_active),
  .status     (alert_status),
  .ie         (irq_en),
  .clr        (clr_pulse)
);

// File: tb/thermal_alert_ctrl_tb.sv
`timescale 1ns/1ps
module thermal_alert_ctrl_tb;
  localparam int ADDR_W   = 8;
  localparam int PRESCALE = 4;
  localparam logic [ADDR_W-1:0] A_RUN  = 8'h00;
  localparam logic [ADDR_W-1:0] A_MODE = 8'h04;
  localparam logic [ADDR_W-1:0] A_REP  = 8'h08;
  localparam logic [ADDR_W-1:0] A_THR0 = 8'h10;
  localparam logic [ADDR_W-1:0] A_INT  = 8'h20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              temp_valid = 1'b0;
  logic [8:0]        temp_value = '0;
  logic              sample_req;
  logic              alert_irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  thermal_alert_ctrl #(.ADDR_W(ADDR_W), .PRESCALE(PRESCALE)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .temp_valid(temp_valid),
    .temp_value(temp_value), .sample_req(sample_req), .alert_irq(alert_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic apply_sample(input logic [8:0] v);
    @(negedge clk); temp_valid = 1'b1; temp_value = v;
    @(negedge clk); temp_valid = 1'b0;
  endtask

  task automatic wait_req(input int lim, output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!sample_req && k < lim);
  endtask

  // reqs seen in a window of n cycles
  task automatic count_req(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sample_req) cnt++;
    end
  endtask

  int thr_set [4][3] = '{'{0, 127, 255}, '{1, 128, 254}, '{100, 50, 200}, '{255, 0, 128}};
  logic [2:0] en_set [4] = '{3'b111, 3'b111, 3'b101, 3'b011};

  initial begin
    logic [31:0] rd;
    int k, cnt, expk;
    logic [2:0] exp_st;
    logic [31:0] exp_word;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, alert_irq}, 32'd0);
    chk("R1 req", {31'd0, sample_req}, 32'd0);
    bus_read(A_RUN, rd);  chk("R1 run", rd, 0);
    bus_read(A_MODE, rd); chk("R1 mode", rd, 0);
    bus_read(A_REP, rd);  chk("R1 repeat", rd, 0);
    for (int c = 0; c < 3; c++) begin
      bus_read(A_THR0 + 8'(4*c), rd); chk("R1 thr", rd, 0);
    end
    bus_read(A_INT, rd); chk("R1 intctl", rd, 0);

    // R2 readback masks (mode != 5 keeps block idle)
    bus_write(A_RUN, 32'hFFFF_FFFF);
    bus_write(A_MODE, 32'hFFFF_FFFF);
    bus_write(A_REP, 32'hFFFF_FFFF);
    for (int c = 0; c < 3; c++) bus_write(A_THR0 + 8'(4*c), 32'hFFFF_FFFF);
    bus_write(A_INT, 32'hFFFF_FFFF);
    bus_write(8'h3C, 32'hFFFF_FFFF);
    bus_write(8'h01, 32'h0);
    bus_read(A_RUN, rd);  chk("R2 run", rd, 32'h1);
    bus_read(A_MODE, rd); chk("R2 mode", rd, 32'hF);
    bus_read(A_REP, rd);  chk("R2 repeat", rd, 32'h0100_000F);
    for (int c = 0; c < 3; c++) begin
      bus_read(A_THR0 + 8'(4*c), rd); chk("R2 thr", rd, 32'h00FF_0001);
    end
    bus_read(A_INT, rd);  chk("R2 intctl", rd, 32'h111);
    bus_read(8'h3C, rd);  chk("R2 unmapped", rd, 0);
    bus_read(8'h01, rd);  chk("R2 misaligned read", rd, 0);
    bus_read(A_RUN, rd);  chk("R2 misaligned write ignored", rd, 32'h1);
    bus_write(A_RUN, 0);
    bus_write(A_REP, 0);
    bus_write(A_INT, 0);

    // R7 inactive: mode wrong, run set
    bus_write(A_MODE, 32'h3);
    bus_write(A_THR0, 32'h0000_0001);
    bus_write(A_REP, 32'h0100_0000);
    bus_write(A_RUN, 1);
    count_req(40, cnt); chk("R7 no req wrong mode", cnt, 0);
    apply_sample(9'd200);
    bus_read(A_INT, rd); chk("R7 no set wrong mode", rd, 0);
    bus_write(A_RUN, 0);
    bus_write(A_MODE, 32'h5);
    count_req(40, cnt); chk("R7 no req run off", cnt, 0);
    apply_sample(9'd200);
    bus_read(A_INT, rd); chk("R7 no set run off", rd, 0);

    // R3 R6 R10 sweep over all samples and several threshold sets
    bus_write(A_REP, 0);
    bus_write(A_RUN, 1);
    bus_write(A_INT, 32'h111);
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 3; c++)
        bus_write(A_THR0 + 8'(4*c), (32'(thr_set[s][c]) << 16) | 32'(en_set[s][c]));
      for (int v = 0; v < 512; v++) begin
        for (int c = 0; c < 3; c++)
          exp_st[c] = en_set[s][c] && (v < 256) && ((v % 256) > thr_set[s][c]);
        apply_sample(9'(v));
        chk("R6 irq latency", {31'd0, alert_irq}, 32'd0);
        @(negedge clk);
        chk("R6 irq", {31'd0, alert_irq}, {31'd0, |exp_st});
        exp_word = 32'h111 | (32'(exp_st[0]) << 1) | (32'(exp_st[1]) << 5) | (32'(exp_st[2]) << 9);
        bus_read(A_INT, rd);
        chk("R3 R10 status", rd, exp_word);
        bus_write(A_INT, 32'h777);
        @(negedge clk);
      end
    end

    // R4 sticky and clear
    for (int c = 0; c < 3; c++) bus_write(A_THR0 + 8'(4*c), 32'h0);
    bus_write(A_THR0, 32'h0032_0001);
    apply_sample(9'd100);
    apply_sample(9'd10);
    bus_read(A_INT, rd); chk("R4 sticky", rd, 32'h113);
    bus_write(A_INT, 32'h111);
    bus_read(A_INT, rd); chk("R4 zero clear ignored", rd, 32'h113);
    bus_write(A_INT, 32'h115);
    bus_read(A_INT, rd); chk("R4 clear", rd, 32'h111);

    // R5 set beats simultaneous clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_INT; bus_wdata = 32'h115;
    temp_valid = 1'b1; temp_value = 9'd100;
    @(negedge clk);
    bus_wr = 1'b0; temp_valid = 1'b0;
    bus_read(A_INT, rd); chk("R5 set wins", rd, 32'h113);

    // R6 interrupt enable gating
    bus_write(A_INT, 32'h004);
    apply_sample(9'd100);
    @(negedge clk); @(negedge clk);
    chk("R6 masked", {31'd0, alert_irq}, 32'd0);
    bus_write(A_INT, 32'h001);
    chk("R6 enable latency", {31'd0, alert_irq}, 32'd0);
    @(negedge clk);
    chk("R6 enabled", {31'd0, alert_irq}, 32'd1);
    bus_write(A_INT, 32'h005);
    @(negedge clk);
    chk("R6 cleared", {31'd0, alert_irq}, 32'd0);

    // R8 endless pacing, all codes plus an out-of-range code
    for (int code = 0; code <= 10; code++) begin
      int cv;
      cv = (code == 10) ? 15 : code;
      expk = PRESCALE << ((cv > 9) ? 9 : cv);
      bus_write(A_RUN, 0);
      bus_write(A_REP, 32'h0100_0000 | 32'(cv));
      bus_write(A_RUN, 1);
      k = 0;
      while (!sample_req && k < 5000) begin @(negedge clk); k++; end
      chk("R8 first interval", k, expk);
      wait_req(5000, k);
      chk("R8 period", k, expk);
    end

    // R9 one-shot
    bus_write(A_RUN, 0);
    bus_write(A_REP, 32'h2);
    bus_write(A_RUN, 1);
    count_req(6 * (PRESCALE << 2), cnt); chk("R9 single request", cnt, 1);
    bus_write(A_RUN, 0);
    bus_write(A_RUN, 1);
    count_req(6 * (PRESCALE << 2), cnt); chk("R9 rearmed", cnt, 1);
    bus_write(A_RUN, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule